// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block watches for a stalled processor. A free-running prescale divider feeds a tick into a two-bit stage counter. The divider tap that makes the tick is chosen by a period code. Software must write a service key to the clear register before the stage counter reaches its fourth tick. If it does not, the block signals an overflow. Depending on the response bit, the overflow is either a one-cycle reset request or a one-cycle interrupt.

The service key clears only the stage counter; the divider keeps its phase. The time from a service write to the overflow therefore lies between three quarters of the selected period and the full period, and software should service faster than 3T/4. The watchdog runs as soon as reset is released. Turning it off takes a two-step unlock sequence. A halt input freezes both the divider and the counter while the system sleeps or waits for its oscillator.

Top module: `keyed_wdt`

## Requirements
- R1: While `rst_n` is low, `rst_req` and `irq` are 0. Reset leaves the control register with run=1, period code 0 and response select = reset.
- R2: The control register is written when `wr_en`=1 and `wr_sel`=0. Bit 0 selects the response (1 = reset request, 0 = interrupt), bits 2:1 hold the period code c and bit 3 holds run. The period is T = 2^(BASE_LOG2 + 2*(3-c)) active cycles, so the defaults give 2^25, 2^23, 2^21 and 2^19. The stage counter advances once every T/4 active cycles.
- R3: Writing 0x4E to the clear register (`wr_en`=1, `wr_sel`=1) zeroes the stage counter and leaves the divider alone. Let d be the divider value at the write edge and q=T/4. The overflow output then rises n active edges later, where n = 3q + ((q-1-d) mod q), with a remainder of 0 counted as q. This gives 3T/4 < n <= T.
- R4: Any other value written to the clear register leaves the stage counter unchanged.
- R5: With response bit 1 an overflow gives a one-cycle `rst_req`; with bit 0 it gives a one-cycle `irq`. The two are never high together.
- R6: After an overflow the stage counter wraps to zero and keeps counting. With no service writes, the next overflow comes exactly T active cycles later.
- R7: While `halt` is 1, the divider and the stage counter hold their values. Counting resumes from those values when `halt` returns to 0.
- R8: A control write with bit 3 = 0 clears run only when the write just before it put 0xB1 into the clear register; otherwise run stays 1. While run is 0, the divider and the counter hold. A control write with bit 3 = 1 always sets run.
- R9: After reset is released, with no software action, the first overflow is a reset request exactly T(code 0) cycles after the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Low-power pause; freezes divider and counter |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 control, 1 clear |
| wr_data | input | 8 | Write data |
| rst_req | output | 1 | One-cycle reset request on overflow |
| irq | output | 1 | One-cycle interrupt on overflow |

## Verification
The assertions check on every cycle that the two outputs are exclusive single-cycle pulses. They also check that each pulse follows an overflow from count 3, that the service key zeroes the counter, and that wrong keys, halt and the disabled state leave the counter frozen. They also check that the run bit cannot be cleared without the unlock key. Only the bench scenarios can show the exact service-to-overflow distance for each period code and divider phase, the exact period of free-running wraps, and that a halted or unlocked-and-stopped watchdog resumes with the right phase.

// File: rtl/kwdt_pkg.sv
`timescale 1ns/1ps
package kwdt_pkg;

  localparam logic [7:0] KEY_SERVICE = 8'h4E;
  localparam logic [7:0] KEY_UNLOCK  = 8'hB1;

  // control register image: bit3 run, bits2:1 period code, bit0 response
  typedef struct packed {
    logic       run;
    logic [1:0] span;
    logic       rst_sel;
  } wd_ctrl_t;

  // log2 of the full detection period for a given code
  function automatic int span_log2(input int base, input int code);
    return base + 2 * (3 - code);
  endfunction

  // log2 of the stage-counter tick interval (a quarter of the period)
  function automatic int tick_log2(input int base, input int code);
    return span_log2(base, code) - 2;
  endfunction

endpackage

// File: rtl/kwdt_regs.sv
`timescale 1ns/1ps
module kwdt_regs
  import kwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output wd_ctrl_t   ctrl,
  output logic       svc_hit,
  output logic       armed
);

  logic     wr_clr;
  logic     wr_ctl;
  logic     unlock_hit;
  wd_ctrl_t ctrl_q;
  logic     armed_q;

  assign wr_clr     = wr_en & wr_sel;
  assign wr_ctl     = wr_en & ~wr_sel;
  assign svc_hit    = wr_clr && (wr_data == KEY_SERVICE);
  assign unlock_hit = wr_clr && (wr_data == KEY_UNLOCK);

  // arming lasts exactly one write: the next write of any kind consumes it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (wr_en) begin
      armed_q <= unlock_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{run: 1'b1, span: 2'b00, rst_sel: 1'b1};
    end else if (wr_ctl) begin
      ctrl_q.rst_sel <= wr_data[0];
      ctrl_q.span    <= wr_data[2:1];
      ctrl_q.run     <= wr_data[3] | ~armed_q;
    end
  end

  assign ctrl  = ctrl_q;
  assign armed = armed_q;

endmodule

// File: rtl/kwdt_prescaler.sv
`timescale 1ns/1ps
module kwdt_prescaler
  import kwdt_pkg::*;
#(
  parameter int BASE_LOG2 = 19,
  localparam int DW     = tick_log2(BASE_LOG2, 0),
  localparam int NCODES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic [1:0] code,
  output logic       tick
);

  logic [DW-1:0]     div_q;
  logic [NCODES-1:0] tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (adv) begin
      div_q <= div_q + 1'b1;
    end
  end

  // one tap per period code: fires when the low bits are all ones
  for (genvar g = 0; g < NCODES; g++) begin : g_tap
    localparam int TL = tick_log2(BASE_LOG2, g);
    assign tap[g] = &div_q[TL-1:0];
  end

  assign tick = adv & tap[code];

endmodule

// File: rtl/kwdt_stage_cnt.sv
`timescale 1ns/1ps
module kwdt_stage_cnt #(
  parameter int CW = 2,
  localparam logic [CW-1:0] TOP = {CW{1'b1}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr,
  input  logic          rst_sel,
  output logic [CW-1:0] cnt,
  output logic          ovf,
  output logic          rst_req,
  output logic          irq
);

  logic [CW-1:0] cnt_q;
  logic          rst_req_q;
  logic          irq_q;

  // a service write in the same cycle as the last tick wins
  assign ovf = tick & (cnt_q == TOP) & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      rst_req_q <= ovf & rst_sel;
      irq_q     <= ovf & ~rst_sel;
    end
  end

  assign cnt     = cnt_q;
  assign rst_req = rst_req_q;
  assign irq     = irq_q;

endmodule

// File: rtl/keyed_wdt.sv
`timescale 1ns/1ps
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int BASE_LOG2 = 19
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic       rst_req,
  output logic       irq
);

  wd_ctrl_t   ctrl_w;
  logic       svc_w;
  logic       armed_w;
  logic       run_w;
  logic       adv_w;
  logic       tick_w;
  logic       ovf_w;
  logic [1:0] cnt_w;

  kwdt_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .ctrl    (ctrl_w),
    .svc_hit (svc_w),
    .armed   (armed_w)
  );

  assign run_w = ctrl_w.run;
  assign adv_w = run_w & ~halt;

  kwdt_prescaler #(.BASE_LOG2(BASE_LOG2)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv_w),
    .code  (ctrl_w.span),
    .tick  (tick_w)
  );

  kwdt_stage_cnt #(.CW(2)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_w),
    .clr     (svc_w),
    .rst_sel (ctrl_w.rst_sel),
    .cnt     (cnt_w),
    .ovf     (ovf_w),
    .rst_req (rst_req),
    .irq     (irq)
  );

endmodule

// File: rtl/kwdt_checker.sv
`timescale 1ns/1ps
module kwdt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       halt,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic       rst_req,
  input logic       irq,
  input logic       run,
  input logic       armed,
  input logic       tick,
  input logic       ovf,
  input logic       svc_hit,
  input logic [1:0] cnt
);

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_req, irq}));

  a_r5_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r6_pulse_after_top: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || irq) |-> ($past(cnt) == 2'd3));

  a_r6_ovf_reaches_port: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (rst_req || irq));

  a_r3_service_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hit |=> (cnt == 2'd0));

  a_r4_wrong_key_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && (wr_data != 8'h4E) && !tick) |=> $stable(cnt));

  a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !svc_hit) |=> $stable(cnt));

  a_r8_locked_run: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !wr_data[3] && !armed && run) |=> run);

  a_r8_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !svc_hit) |=> $stable(cnt));

endmodule

bind keyed_wdt kwdt_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .halt    (halt),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .rst_req (rst_req),
  .irq     (irq),
  .run     (run_w),
  .armed   (armed_w),
  .tick    (tick_w),
  .ovf     (ovf_w),
  .svc_hit (svc_w),
  .cnt     (cnt_w)
);

// File: tb/test_keyed_wdt.sv
`timescale 1ns/1ps
module test_keyed_wdt;

  localparam int BASE = 3;   // periods 512, 128, 32, 8 cycles

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rst_req;
  logic       irq;

  int tests = 0;
  int fails = 0;
  int act = 0;        // active (counting) edges since reset = divider value
  bit en_m = 1'b1;

  always #2 clk = ~clk;

  keyed_wdt #(.BASE_LOG2(BASE)) i_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .halt(halt), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rst_req(rst_req), .irq(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) act <= 0;
    else if (en_m && !halt) act <= act + 1;
  end

  function automatic int quarter(input int code);
    return 1 << (BASE + 4 - 2 * code);
  endfunction

  function automatic int gap(input int d, input int q);
    int j1;
    j1 = q - 1 - (d % q);
    if (j1 == 0) j1 = q;
    return j1 + 3 * q;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic do_write(input logic sel, input logic [7:0] data, output int d);
    wr_en = 1'b1; wr_sel = sel; wr_data = data; d = act;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
  endtask

  // kind: 1 reset request, 2 interrupt, 3 both, 0 none within limit
  task automatic measure(input int limit, output int n, output int kind);
    n = 0; kind = 0;
    while (n < limit && kind == 0) begin
      step(1);
      n++;
      kind = (rst_req ? 1 : 0) + (irq ? 2 : 0);
    end
    if (kind == 0) n = -1;
  endtask

  task automatic set_ctrl(input logic run, input int code, input logic rsel);
    int dd;
    logic [1:0] c2;
    c2 = code[1:0];
    do_write(1'b1, 8'h4E, dd);
    do_write(1'b0, {4'h0, run, c2, rsel}, dd);
    do_write(1'b1, 8'h4E, dd);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d, n, k, m, q, e, cnt_p;
    @(negedge clk); @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1 rst_req in reset", int'(rst_req), 0);
    chk("R1 irq in reset", int'(irq), 0);
    rst_n = 1'b1;

    // R9: first overflow without any software action, as a reset request
    measure(2000, n, k);
    chk("R9 first overflow time", n, 512);
    chk("R9 default response", k, 1);
    step(1);
    chk("R5 reset request one cycle", int'(rst_req), 0);
    measure(2000, m, k);
    chk("R6 free-running wrap period", m + 1, 512);
    chk("R6 wrap response", k, 1);

    // R2, R3, R5: every period code, both responses, many divider phases
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 2; s++) begin
        set_ctrl(1'b1, c, s[0]);
        q = quarter(c);
        for (int p = 0; p < ((q < 8) ? q : 8); p++) begin
          step(p);
          do_write(1'b1, 8'h4E, d);
          measure(2000, n, k);
          chk("R3 service-to-overflow", n, gap(d, q));
          chk("R2 window", int'(n > 3 * q && n <= 4 * q), 1);
          chk("R5 response select", k, (s == 1) ? 1 : 2);
          step(1);
          chk("R5 pulse width", int'(rst_req | irq), 0);
        end
      end
    end

    // R4: wrong keys do not restart the count (code 2, interrupt)
    set_ctrl(1'b1, 2, 1'b0);
    q = quarter(2);
    do_write(1'b1, 8'h4E, d);
    step(3);
    do_write(1'b1, 8'h4F, e);
    do_write(1'b1, 8'h00, e);
    do_write(1'b1, 8'hE4, e);
    measure(2000, m, k);
    chk("R4 wrong key ignored", 6 + m, gap(d, q));

    // R7: halt freezes divider and counter; no overflow while halted
    do_write(1'b1, 8'h4E, d);
    halt = 1'b1;
    cnt_p = 0;
    for (int i = 0; i < 300; i++) begin
      step(1);
      if (rst_req || irq) cnt_p++;
    end
    chk("R7 no overflow while halted", cnt_p, 0);
    halt = 1'b0;
    measure(2000, m, k);
    chk("R7 resume from held phase", m, gap(d, q));

    // R7: halt in mid-count stretches the gap by the halted cycles
    do_write(1'b1, 8'h4E, d);
    step(5);
    halt = 1'b1;
    step(13);
    halt = 1'b0;
    measure(2000, m, k);
    chk("R7 mid-count halt", 5 + 13 + m, gap(d, q) + 13);

    // R8: disable without unlock is refused
    do_write(1'b1, 8'h4E, d);
    do_write(1'b0, 8'h04, e);
    measure(2000, m, k);
    chk("R8 disable refused", 1 + m, gap(d, q));

    // R8: unlock broken by an intervening write is refused
    do_write(1'b1, 8'hB1, e);
    do_write(1'b1, 8'h4E, d);
    do_write(1'b0, 8'h04, e);
    measure(2000, m, k);
    chk("R8 broken unlock refused", 1 + m, gap(d, q));

    // R8: proper unlock stops counting; re-enable resumes the held state
    do_write(1'b1, 8'h4E, d);
    do_write(1'b1, 8'hB1, e);
    do_write(1'b0, 8'h04, e);
    en_m = 1'b0;
    cnt_p = 0;
    for (int i = 0; i < 600; i++) begin
      step(1);
      if (rst_req || irq) cnt_p++;
    end
    chk("R8 stopped watchdog silent", cnt_p, 0);
    do_write(1'b0, 8'h0C, e);
    en_m = 1'b1;
    measure(2000, m, k);
    chk("R8 resume after re-enable", 2 + m, gap(d, q));
    chk("R8 resumed response", k, 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule